// File: doc/BRIEF.md
# Doorbell Handshake Message Engine

This block gives a host a way to pass short control messages to a controller, and to collect the replies, through a single doorbell register instead of memory-resident queues. When no handshake is open, a host write to the doorbell is treated as a command word. Its top byte is a function code. For a handshake, the byte below it is the number of request dwords to follow. After a handshake command, each doorbell write stores one request dword. When the announced number has arrived, a one-cycle message-done strobe tells the decoding logic that it can read the buffer through a random-access port.

The decoding logic hands its reply back as a valid/ready stream of dwords that ends with a last flag. Ready is high only while the engine is collecting a request. Outside that phase a word offered on the stream is held and not taken, so the producer has to keep valid and its data steady until ready appears. After the last word, every host doorbell read returns the controller state in the upper half and the next 16-bit piece of the reply in the lower half. The low half of each dword comes first.

The engine owns the doorbell interrupt bit and the rules that clear it. A write to the interrupt-status register clears the bit unless a reply is being drained. During a drain the bit stays set, and the write closes the handshake once every reply half has been read. A reply that the controller sends through its queue path while a handshake request is open also closes the handshake and raises the bit.

Top module: `doorbell_hs_engine`

## Requirements
- R1: After reset the engine is idle. `db_irq`, `msg_done`, `unit_reset` and `rpl_ready` are 0, and `db_rd_data` equals `ioc_state`.
- R2: A doorbell write made outside the fill phase with function byte (bits 31:24) 0x42 opens the fill phase and sets `db_irq` one cycle later. While the fill phase lasts, `db_rd_data` equals `ioc_state` with bit 27 (active) set.
- R3: The request length is taken from bits 23:16 of the handshake write and is limited to the buffer depth (64 dwords). `msg_len` shows the limited value.
- R4: In the fill phase each doorbell write stores one dword at the next index, starting at 0, until the length is reached. The write that reaches the length makes `msg_done` high for exactly the following cycle. Later writes leave the buffer unchanged.
- R5: A handshake with length 0 never raises `msg_done`.
- R6: Function byte 0x40 outside the fill phase returns the engine to idle, clears `db_irq` and pulses `unit_reset` for one cycle. Byte 0x41 and every other byte other than 0x42 change nothing.
- R7: `rpl_ready` is high only in the fill phase. A transfer with `rpl_last` set enters the drain phase and sets `db_irq`. The reply then holds twice as many halves as dwords were accepted.
- R8: In the drain phase a doorbell read returns `ioc_state[31:16]` with bit 27 set in the upper half. The lower half is the next reply half, low half of each dword first, and the read moves on by one half. Once every half has been read, the lower half reads 0 and stays 0.
- R9: An interrupt-status write clears `db_irq` in the idle and fill phases. In the drain phase it leaves `db_irq` set, and it returns the engine to idle only when every reply half has been read.
- R10: A pulse on `q_reply_post` in the fill phase returns the engine to idle and sets `db_irq`. In the other phases it has no effect.
- R11: Reply dwords beyond 64 are accepted and discarded, so the reply never holds more than 128 halves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| db_wr_valid | input | 1 | Host write strobe for the doorbell register |
| db_wr_data | input | 32 | Doorbell write value |
| db_rd_en | input | 1 | Host read strobe for the doorbell register; advances the reply in the drain phase |
| db_rd_data | output | 32 | Value a doorbell read returns in this cycle |
| isr_wr | input | 1 | Host write strobe for the interrupt-status register |
| ioc_state | input | 32 | Controller state word reported through the doorbell |
| msg_done | output | 1 | One-cycle strobe: request buffer complete |
| msg_len | output | 7 | Limited request length in dwords |
| msg_rd_addr | input | 6 | Request buffer read index |
| msg_rd_data | output | 32 | Request dword at `msg_rd_addr` |
| rpl_valid | input | 1 | Reply stream word valid |
| rpl_ready | output | 1 | Reply stream ready (fill phase only) |
| rpl_data | input | 32 | Reply stream dword |
| rpl_last | input | 1 | Marks the final reply dword |
| q_reply_post | input | 1 | Strobe: a reply left through the queue path |
| db_irq | output | 1 | Doorbell interrupt bit |
| unit_reset | output | 1 | One-cycle soft-reset request |

## Verification
The properties check on every cycle that entering the fill phase raises the interrupt, that the request length never exceeds the buffer, that the message-done strobe lasts one cycle and never follows a zero length, and that ready is confined to the fill phase. They also check that a queue-path reply aborts an open fill, that a status write never drops the interrupt during a drain, and that each drain read advances the half index by one. The bench scenarios are the only way to show data ordering: dwords land at the right buffer slots, halves come out low first, and the length clamp and reply overflow drop exactly the surplus. The exact upper-half value a host reads in each phase is also shown only by the scenarios.

// File: rtl/db_hs_pkg.sv
package db_hs_pkg;

  typedef enum logic [1:0] {
    HS_IDLE  = 2'd0,
    HS_FILL  = 2'd1,
    HS_DRAIN = 2'd2
  } hs_state_e;

  // function byte values decoded from a doorbell command write
  localparam logic [7:0] FN_UNIT_RESET = 8'h40;
  localparam logic [7:0] FN_IO_RESET   = 8'h41;
  localparam logic [7:0] FN_HANDSHAKE  = 8'h42;

  // doorbell word layout
  localparam int FN_MSB     = 31;
  localparam int FN_LSB     = 24;
  localparam int CNT_MSB    = 23;
  localparam int CNT_LSB    = 16;
  localparam int ACTIVE_BIT = 27;

endpackage

// File: rtl/db_msg_store.sv
module db_msg_store #(
  parameter  int DEPTH = 64,
  localparam int AW    = $clog2(DEPTH),
  localparam int LW    = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [7:0]    cnt_in,
  input  logic          wr_en,
  input  logic [31:0]   wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [LW-1:0] len,
  output logic          done,
  output logic [31:0]   rd_data
);

  logic [31:0]   mem [DEPTH];
  logic [LW-1:0] idx;
  logic [LW-1:0] clamp_len;
  logic          accept;

  // limit the announced dword count to the buffer depth
  always_comb begin
    if (int'(cnt_in) > DEPTH) clamp_len = LW'(DEPTH);
    else                      clamp_len = LW'(cnt_in);
  end

  assign accept = wr_en && (idx < len) && !start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx  <= '0;
      len  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        idx <= '0;
        len <= clamp_len;
      end else if (accept) begin
        idx <= idx + LW'(1);
        if (idx + LW'(1) == len) done <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (accept) mem[idx[AW-1:0]] <= wr_data;
  end

  assign rd_data = mem[rd_addr];

endmodule

// File: rtl/db_reply_store.sv
module db_reply_store #(
  parameter  int HALVES = 128,
  localparam int WORDS  = HALVES / 2,
  localparam int WAW    = $clog2(WORDS),
  localparam int HW     = $clog2(HALVES) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          push,
  input  logic [31:0]   push_data,
  input  logic          step,
  output logic [HW-1:0] size,
  output logic [HW-1:0] idx,
  output logic [15:0]   half
);

  logic [31:0]  mem [WORDS];
  logic [WAW:0] wcnt;
  logic         room;
  logic [31:0]  cur_word;

  assign room = (int'(wcnt) < WORDS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt <= '0;
      idx  <= '0;
    end else if (clear) begin
      wcnt <= '0;
      idx  <= '0;
    end else begin
      if (push && room) wcnt <= wcnt + 1'b1;
      if (step)         idx  <= idx + HW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (push && room && !clear) mem[wcnt[WAW-1:0]] <= push_data;
  end

  // two halves per stored dword
  assign size     = HW'({wcnt, 1'b0});
  assign cur_word = mem[idx[HW-2:1]];
  assign half     = idx[0] ? cur_word[31:16] : cur_word[15:0];

endmodule

// File: rtl/db_hs_ctrl.sv
module db_hs_ctrl
  import db_hs_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      db_wr_valid,
  input  logic [7:0] func,
  input  logic      db_rd_en,
  input  logic      rpl_fire,
  input  logic      rpl_last,
  input  logic      isr_wr,
  input  logic      q_reply_post,
  input  logic      more,
  output hs_state_e state,
  output logic      irq,
  output logic      hs_start,
  output logic      msg_wr_en,
  output logic      rd_step,
  output logic      unit_reset
);

  hs_state_e state_nx;
  logic      cmd_phase;
  logic      do_reset;
  logic      rpl_done;
  logic      q_abort;
  logic      irq_set;
  logic      irq_clr;

  always_comb begin
    cmd_phase = db_wr_valid && (state != HS_FILL);
    hs_start  = cmd_phase && (func == FN_HANDSHAKE);
    // FN_IO_RESET and all other codes fall through with no action
    do_reset  = cmd_phase && (func == FN_UNIT_RESET);
    msg_wr_en = db_wr_valid && (state == HS_FILL);
    rd_step   = db_rd_en && (state == HS_DRAIN) && more;
    rpl_done  = rpl_fire && rpl_last && (state == HS_FILL);
    q_abort   = q_reply_post && (state == HS_FILL);
    irq_set   = hs_start || rpl_done || q_abort;
    irq_clr   = do_reset || (isr_wr && (state != HS_DRAIN));
  end

  always_comb begin
    state_nx = state;
    unique case (state)
      HS_IDLE: begin
        if (hs_start) state_nx = HS_FILL;
      end
      HS_FILL: begin
        if (q_abort)       state_nx = HS_IDLE;
        else if (rpl_done) state_nx = HS_DRAIN;
      end
      HS_DRAIN: begin
        if (hs_start)              state_nx = HS_FILL;
        else if (do_reset)         state_nx = HS_IDLE;
        else if (isr_wr && !more)  state_nx = HS_IDLE;
      end
      default: state_nx = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= HS_IDLE;
      irq        <= 1'b0;
      unit_reset <= 1'b0;
    end else begin
      state      <= state_nx;
      unit_reset <= do_reset;
      if (irq_set)      irq <= 1'b1;
      else if (irq_clr) irq <= 1'b0;
    end
  end

endmodule

// File: rtl/doorbell_hs_engine.sv
module doorbell_hs_engine
  import db_hs_pkg::*;
#(
  parameter  int MSG_DWORDS = 64,
  parameter  int RPL_HALVES = 128,
  localparam int MAW        = $clog2(MSG_DWORDS),
  localparam int MLW        = MAW + 1,
  localparam int HW         = $clog2(RPL_HALVES) + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           db_wr_valid,
  input  logic [31:0]    db_wr_data,
  input  logic           db_rd_en,
  output logic [31:0]    db_rd_data,
  input  logic           isr_wr,
  input  logic [31:0]    ioc_state,
  output logic           msg_done,
  output logic [MLW-1:0] msg_len,
  input  logic [MAW-1:0] msg_rd_addr,
  output logic [31:0]    msg_rd_data,
  input  logic           rpl_valid,
  output logic           rpl_ready,
  input  logic [31:0]    rpl_data,
  input  logic           rpl_last,
  input  logic           q_reply_post,
  output logic           db_irq,
  output logic           unit_reset
);

  hs_state_e      st;
  logic           hs_start;
  logic           msg_wr_en;
  logic           rd_step;
  logic           rpl_fire;
  logic           more;
  logic [HW-1:0]  rd_size;
  logic [HW-1:0]  rd_idx;
  logic [15:0]    rd_half;
  logic [31:0]    active_mask;

  assign rpl_ready   = (st == HS_FILL);
  assign rpl_fire    = rpl_valid && rpl_ready;
  assign more        = (rd_idx < rd_size);
  assign active_mask = 32'(1) << ACTIVE_BIT;

  db_hs_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .db_wr_valid  (db_wr_valid),
    .func         (db_wr_data[FN_MSB:FN_LSB]),
    .db_rd_en     (db_rd_en),
    .rpl_fire     (rpl_fire),
    .rpl_last     (rpl_last),
    .isr_wr       (isr_wr),
    .q_reply_post (q_reply_post),
    .more         (more),
    .state        (st),
    .irq          (db_irq),
    .hs_start     (hs_start),
    .msg_wr_en    (msg_wr_en),
    .rd_step      (rd_step),
    .unit_reset   (unit_reset)
  );

  db_msg_store #(.DEPTH(MSG_DWORDS)) u_msg (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (hs_start),
    .cnt_in  (db_wr_data[CNT_MSB:CNT_LSB]),
    .wr_en   (msg_wr_en),
    .wr_data (db_wr_data),
    .rd_addr (msg_rd_addr),
    .len     (msg_len),
    .done    (msg_done),
    .rd_data (msg_rd_data)
  );

  db_reply_store #(.HALVES(RPL_HALVES)) u_rpl (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (hs_start),
    .push      (rpl_fire),
    .push_data (rpl_data),
    .step      (rd_step),
    .size      (rd_size),
    .idx       (rd_idx),
    .half      (rd_half)
  );

  // host-visible doorbell value for the current phase
  always_comb begin
    unique case (st)
      HS_FILL:  db_rd_data = ioc_state | active_mask;
      HS_DRAIN: db_rd_data = {ioc_state[31:16], 16'h0000} | active_mask
                             | {16'h0000, (more ? rd_half : 16'h0000)};
      default:  db_rd_data = ioc_state;
    endcase
  end

endmodule

// File: rtl/db_hs_checker.sv
module db_hs_checker
  import db_hs_pkg::*;
#(
  parameter int MSG_DWORDS = 64,
  parameter int MLW        = 7,
  parameter int HW         = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic [1:0]     st,
  input logic           db_wr_valid,
  input logic [7:0]     db_func,
  input logic           db_rd_en,
  input logic           isr_wr,
  input logic           q_reply_post,
  input logic           msg_done,
  input logic [MLW-1:0] msg_len,
  input logic           rpl_ready,
  input logic           db_irq,
  input logic           unit_reset,
  input logic [HW-1:0]  rd_idx,
  input logic [HW-1:0]  rd_size
);

  p_enter_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (db_wr_valid && st != HS_FILL && db_func == FN_HANDSHAKE) |=> (st == HS_FILL && db_irq));

  p_len_clamp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    msg_len <= MLW'(MSG_DWORDS));

  p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    msg_done |=> !msg_done);

  p_no_done_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    msg_done |-> (msg_len != '0));

  p_reset_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    unit_reset |-> !db_irq);

  p_ready_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rpl_ready |-> (st == HS_FILL));

  p_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == HS_DRAIN && db_rd_en && !db_wr_valid && rd_idx < rd_size)
      |=> rd_idx == HW'($past(rd_idx) + 1'b1));

  p_idx_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == HS_DRAIN) |-> rd_idx <= rd_size);

  p_irq_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == HS_DRAIN && isr_wr && !db_wr_valid) |=> db_irq);

  p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == HS_FILL && q_reply_post) |=> (st == HS_IDLE && db_irq));

endmodule

bind doorbell_hs_engine db_hs_checker #(
  .MSG_DWORDS (MSG_DWORDS),
  .MLW        (MLW),
  .HW         (HW)
) u_hs_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .st           (st),
  .db_wr_valid  (db_wr_valid),
  .db_func      (db_wr_data[31:24]),
  .db_rd_en     (db_rd_en),
  .isr_wr       (isr_wr),
  .q_reply_post (q_reply_post),
  .msg_done     (msg_done),
  .msg_len      (msg_len),
  .rpl_ready    (rpl_ready),
  .db_irq       (db_irq),
  .unit_reset   (unit_reset),
  .rd_idx       (rd_idx),
  .rd_size      (rd_size)
);

// File: tb/test_doorbell_hs_engine.sv
module test_doorbell_hs_engine;

  localparam logic [31:0] IOC    = 32'h2000_1234;
  localparam logic [31:0] ACTV   = 32'h0800_0000;
  localparam logic [31:0] MSG_VEC [8] = '{
    32'h1111_0001, 32'h2222_0002, 32'hA5A5_5A5A, 32'h0000_0000,
    32'hFFFF_FFFF, 32'h1234_5678, 32'h8000_0001, 32'h0F0F_F0F0
  };
  localparam logic [31:0] RPL_VEC [3] = '{
    32'hA1B2_C3D4, 32'h0102_0304, 32'hFFEE_0011
  };

  logic        clk = 0;
  logic        rst_n = 0;
  logic        db_wr_valid = 0;
  logic [31:0] db_wr_data = '0;
  logic        db_rd_en = 0;
  logic [31:0] db_rd_data;
  logic        isr_wr = 0;
  logic [31:0] ioc_state = IOC;
  logic        msg_done;
  logic [6:0]  msg_len;
  logic [5:0]  msg_rd_addr = '0;
  logic [31:0] msg_rd_data;
  logic        rpl_valid = 0;
  logic        rpl_ready;
  logic [31:0] rpl_data = '0;
  logic        rpl_last = 0;
  logic        q_reply_post = 0;
  logic        db_irq;
  logic        unit_reset;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  doorbell_hs_engine i_doorbell_hs_engine (
    .clk(clk), .rst_n(rst_n), .db_wr_valid(db_wr_valid), .db_wr_data(db_wr_data),
    .db_rd_en(db_rd_en), .db_rd_data(db_rd_data), .isr_wr(isr_wr), .ioc_state(ioc_state),
    .msg_done(msg_done), .msg_len(msg_len), .msg_rd_addr(msg_rd_addr),
    .msg_rd_data(msg_rd_data), .rpl_valid(rpl_valid), .rpl_ready(rpl_ready),
    .rpl_data(rpl_data), .rpl_last(rpl_last), .q_reply_post(q_reply_post),
    .db_irq(db_irq), .unit_reset(unit_reset)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic dbw(input logic [31:0] d);
    @(negedge clk); db_wr_valid = 1; db_wr_data = d;
    @(negedge clk); db_wr_valid = 0;
  endtask

  task automatic dbr(output logic [31:0] v);
    @(negedge clk); db_rd_en = 1; #1 v = db_rd_data;
    @(negedge clk); db_rd_en = 0;
  endtask

  task automatic isr_pulse();
    @(negedge clk); isr_wr = 1;
    @(negedge clk); isr_wr = 0;
  endtask

  task automatic qpost();
    @(negedge clk); q_reply_post = 1;
    @(negedge clk); q_reply_post = 0;
  endtask

  task automatic push(input logic [31:0] d, input logic l);
    @(negedge clk); rpl_valid = 1; rpl_data = d; rpl_last = l;
    @(negedge clk); rpl_valid = 0; rpl_last = 0;
  endtask

  function automatic logic [31:0] drain_exp(input logic [15:0] h);
    return (IOC & 32'hFFFF_0000) | ACTV | {16'h0, h};
  endfunction

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hang expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 rd", db_rd_data, IOC);
    chk("R1 irq", {31'b0, db_irq}, 0);
    chk("R1 done", {31'b0, msg_done}, 0);
    chk("R1 ready", {31'b0, rpl_ready}, 0);
    chk("R1 ureset", {31'b0, unit_reset}, 0);
    rst_n = 1;
    @(negedge clk);

    // R7: no ready while idle
    chk("R7 idle ready", {31'b0, rpl_ready}, 0);

    // R2 handshake, 8 dwords
    dbw(32'h4208_0000);
    chk("R2 irq", {31'b0, db_irq}, 1);
    chk("R2 active", db_rd_data, IOC | ACTV);
    chk("R3 len", {25'b0, msg_len}, 8);
    // R9 status write in fill clears irq
    isr_pulse();
    chk("R9 fill clear", {31'b0, db_irq}, 0);

    // R4 vector table walked by one loop
    for (int i = 0; i < 8; i++) begin
      dbw(MSG_VEC[i]);
      chk("R4 done", {31'b0, msg_done}, (i == 7) ? 1 : 0);
    end
    @(negedge clk);
    chk("R4 done pulse", {31'b0, msg_done}, 0);
    dbw(32'hDEAD_BEEF);
    chk("R4 drop done", {31'b0, msg_done}, 0);
    for (int i = 0; i < 8; i++) begin
      msg_rd_addr = 6'(i); #1;
      chk("R4 buf", msg_rd_data, MSG_VEC[i]);
    end

    // R7 reply load
    chk("R7 fill ready", {31'b0, rpl_ready}, 1);
    push(RPL_VEC[0], 0);
    push(RPL_VEC[1], 0);
    push(RPL_VEC[2], 1);
    chk("R7 irq", {31'b0, db_irq}, 1);
    chk("R7 ready off", {31'b0, rpl_ready}, 0);

    // R8 halves, low first; R9 status write mid-drain
    for (int h = 0; h < 6; h++) begin
      dbr(v);
      chk("R8 half", v, drain_exp(h[0] ? RPL_VEC[h/2][31:16] : RPL_VEC[h/2][15:0]));
      if (h == 2) begin
        isr_pulse();
        chk("R9 drain keep irq", {31'b0, db_irq}, 1);
        chk("R9 drain stays", db_rd_data, drain_exp(RPL_VEC[1][31:16]));
      end
    end
    dbr(v);
    chk("R8 empty", v, drain_exp(16'h0));
    isr_pulse();
    chk("R9 to idle", db_rd_data, IOC);
    chk("R9 irq kept", {31'b0, db_irq}, 1);
    isr_pulse();
    chk("R9 idle clear", {31'b0, db_irq}, 0);

    // R3 clamp
    dbw(32'h4250_0000);
    chk("R3 clamp", {25'b0, msg_len}, 64);
    for (int i = 0; i < 64; i++) begin
      dbw(32'(i) + 32'h100);
      if (i == 63) chk("R3 done at 64", {31'b0, msg_done}, 1);
    end
    msg_rd_addr = 6'd63; #1;
    chk("R3 last slot", msg_rd_data, 32'h13F);

    // R10 queue-path reply aborts fill
    isr_pulse();
    qpost();
    chk("R10 idle", db_rd_data, IOC);
    chk("R10 irq", {31'b0, db_irq}, 1);
    isr_pulse();
    qpost();
    chk("R10 idle no effect", {31'b0, db_irq}, 0);

    // R5 zero length
    dbw(32'h4200_0000);
    chk("R5 len", {25'b0, msg_len}, 0);
    dbw(32'h5555_5555);
    chk("R5 no done", {31'b0, msg_done}, 0);
    qpost();

    // R6 unit reset and ignored codes
    dbw(32'h4000_0000);
    chk("R6 pulse", {31'b0, unit_reset}, 1);
    chk("R6 irq", {31'b0, db_irq}, 0);
    @(negedge clk);
    chk("R6 one cycle", {31'b0, unit_reset}, 0);
    dbw(32'h4201_0000);
    qpost();
    dbw(32'h4100_0000);
    chk("R6 io reset irq", {31'b0, db_irq}, 1);
    chk("R6 io reset state", db_rd_data, IOC);
    chk("R6 io no pulse", {31'b0, unit_reset}, 0);
    dbw(32'h7700_0000);
    chk("R6 other", db_rd_data, IOC);
    chk("R6 other irq", {31'b0, db_irq}, 1);

    // R11 reply overflow
    dbw(32'h4201_0000);
    dbw(32'hCAFE_0000);
    for (int i = 0; i < 70; i++)
      push({16'(i + 32'h100), 16'(i)}, i == 69);
    for (int h = 0; h < 128; h++) begin
      dbr(v);
      chk("R11 half", v, drain_exp(h[0] ? 16'((h / 2) + 32'h100) : 16'(h / 2)));
    end
    dbr(v);
    chk("R11 end", v, drain_exp(16'h0));
    isr_pulse();
    chk("R11 idle", db_rd_data, IOC);

    finished = 1;
    summary();
    $finish;
  end

endmodule